// File: doc/BRIEF.md
# Paged Remote DMA Port Engine

This engine lets a host move a burst of bytes between itself and a local packet buffer RAM through a single data port. The host sets a 16-bit start pointer and a 16-bit byte count. Each value is written as two byte-wide registers. The host then issues a read or a write command and performs repeated accesses on the data port. The engine walks the pointer through the RAM, one byte per RAM cycle. It decrements the count and raises a completion status bit when the count is exhausted. The host polls that bit and clears it by writing a one.

The engine has a byte mode and a word mode. In byte mode one data-port access moves one byte. In word mode one access moves two consecutive bytes, and an odd count is first rounded up to an even value. The RAM is byte wide with one cycle of read latency, so a word access occupies two RAM cycles. The `port_ready` output tells the host when the next data-port access may be made. Completion is also brought out on `dma_done`.

The controller has six states:
- `ST_IDLE`: no burst is active.
- `ST_RD_ARM`: a read burst is waiting for a data-port read.
- `ST_RD_FETCH`: the RAM read for the current pointer is issued.
- `ST_RD_TAKE`: the returned byte is captured and the pointer steps.
- `ST_WR_ARM`: a write burst is waiting for a data-port write.
- `ST_WR_PUT`: one byte is written and the pointer steps.

The transitions are:
- A read command goes from any state to `ST_RD_ARM`, or to `ST_IDLE` if the count is zero.
- A write command goes from any state to `ST_WR_ARM`, or to `ST_IDLE` if the count is zero.
- An abort command goes from any state to `ST_IDLE`.
- `ST_RD_ARM` goes to `ST_RD_FETCH` on a port read.
- `ST_RD_FETCH` always goes to `ST_RD_TAKE`.
- `ST_RD_TAKE` goes to `ST_IDLE` on the last byte. For the first byte of a word it goes back to `ST_RD_FETCH`. Otherwise it goes to `ST_RD_ARM`.
- `ST_WR_ARM` goes to `ST_WR_PUT` on a port write.
- `ST_WR_PUT` goes to `ST_IDLE` on the last byte. For the first byte of a word it stays in `ST_WR_PUT`. Otherwise it goes to `ST_WR_ARM`.

Top module: `rdma_port_engine`

## Requirements
- R1: The pointer is loaded through register offset 1 (bits 7:0) and offset 2 (bits 15:8). Reading these offsets returns the current pointer.
- R2: The count is loaded through register offset 3 (bits 7:0) and offset 4 (bits 15:8). Reading these offsets returns the remaining count.
- R3: In byte mode (offset 6 bit 0 = 0), one data-port access moves one byte, then the pointer advances by 1 and the count drops by 1. The byte travels on `port_wdata[7:0]`, or on `port_rdata[7:0]` with the upper bits zero.
- R4: In word mode (offset 6 bit 0 = 1), one data-port access moves two bytes, then the pointer advances by 2 and the count drops by 2. Bits 7:0 go to or come from the pointer address, and bits 15:8 the next address.
- R5: In word mode, issuing a read or write command rounds an odd count up to the next even value.
- R6: The command register is offset 0, with bits 1:0 encoded as 01 read, 10 write, 11 abort and 00 no action. Abort returns the engine to idle and keeps the pointer and count. It does not set the completion bit, and later data-port accesses are ignored.
- R7: When a transfer brings the count to zero, the completion bit (offset 5 bit 0, also `dma_done`) is set. A read or write command issued with a zero count sets it at once.
- R8: Writing 1 to offset 5 bit 0 clears the completion bit. Writing 0 there leaves it unchanged.
- R9: A data-port access is ignored, leaving the pointer, the count and the RAM unchanged, in two cases: when no burst is active (including after the count reached zero), and when the access is in the direction opposite to the active burst.
- R10: The pointer wraps from 0xFFFF to 0x0000.
- R11: Reset clears the pointer, the count and the completion bit, and leaves the engine idle with `port_ready` high.
- R12: `port_ready` is low while a data-port access is being carried out, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| port_rd | input | 1 | Data-port read strobe |
| port_wr | input | 1 | Data-port write strobe |
| port_wdata | input | 16 | Data-port write data |
| port_rdata | output | 16 | Data-port read data, valid when `port_ready` returns |
| port_ready | output | 1 | Engine can accept a data-port access |
| dma_done | output | 1 | Completion status bit |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_en` |

## Verification
On every cycle, the assertions check the following:
- The pointer stays frozen while the engine is idle.
- Each written byte advances the pointer by one.
- The RAM is never written with a zero count.
- The count is even while a word burst waits.
- Completion rises only with a zero count.
- Abort always lands in idle.
- The reset state is correct.

Other behaviour can only be shown by the bench's directed scenarios:
- The byte order of word transfers and the data values read back from RAM.
- Rounding of an odd count as observed through the register readback.
- The write-one-to-clear semantics.
- Pointer wrap.
- Ignoring of accesses made after completion, after abort, or in the wrong direction.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ARM   = 3'd1,
        ST_RD_FETCH = 3'd2,
        ST_RD_TAKE  = 3'd3,
        ST_WR_ARM   = 3'd4,
        ST_WR_PUT   = 3'd5
    } rdma_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_ABORT = 2'b11
    } rdma_cmd_e;

    localparam logic [REG_AW-1:0] OFS_CMD     = 3'd0;
    localparam logic [REG_AW-1:0] OFS_PTR_LO  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_PTR_HI  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CNT_LO  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_CNT_HI  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 3'd5;
    localparam logic [REG_AW-1:0] OFS_CONFIG  = 3'd6;

endpackage

// File: rtl/rdma_regfile.sv
module rdma_regfile
    import rdma_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned PTR_W = 2 * BYTE_W,
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic [PTR_W-1:0]    ptr_addr,
    input  logic [CNT_W-1:0]    ptr_cnt,
    input  logic                done_set,
    output logic                done,
    output logic                word_mode,
    output logic [1:0]          ld_addr,
    output logic [1:0]          ld_cnt,
    output logic                cmd_wr,
    output rdma_cmd_e           cmd_code
);

    logic done_q;
    logic word_q;
    logic status_clr;

    always_comb begin
        ld_addr[0] = reg_wr && (reg_addr == OFS_PTR_LO);
        ld_addr[1] = reg_wr && (reg_addr == OFS_PTR_HI);
        ld_cnt[0]  = reg_wr && (reg_addr == OFS_CNT_LO);
        ld_cnt[1]  = reg_wr && (reg_addr == OFS_CNT_HI);
        cmd_wr     = reg_wr && (reg_addr == OFS_CMD);
        cmd_code   = rdma_cmd_e'(reg_wdata[1:0]);
        status_clr = reg_wr && (reg_addr == OFS_STATUS) && reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            word_q <= 1'b0;
        end else begin
            if (done_set) begin
                done_q <= 1'b1;
            end else if (status_clr) begin
                done_q <= 1'b0;
            end
            if (reg_wr && (reg_addr == OFS_CONFIG)) begin
                word_q <= reg_wdata[0];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_PTR_LO: reg_rdata = ptr_addr[BYTE_W-1:0];
            OFS_PTR_HI: reg_rdata = ptr_addr[PTR_W-1:BYTE_W];
            OFS_CNT_LO: reg_rdata = ptr_cnt[BYTE_W-1:0];
            OFS_CNT_HI: reg_rdata = ptr_cnt[PTR_W-1:BYTE_W];
            OFS_STATUS: reg_rdata = {{(BYTE_W-1){1'b0}}, done_q};
            OFS_CONFIG: reg_rdata = {{(BYTE_W-1){1'b0}}, word_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign done      = done_q;
    assign word_mode = word_q;

endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned PTR_W = 2 * BYTE_W,
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ld_addr,
    input  logic [1:0]        ld_cnt,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              step,
    input  logic              round_en,
    output logic [PTR_W-1:0]  addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_zero,
    output logic              cnt_one
);

    logic [PTR_W-1:0] addr_q, addr_d, addr_stepped;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_adj;

    always_comb begin
        addr_stepped = step ? (addr_q + PTR_W'(1)) : addr_q;
        cnt_adj = cnt_q;
        if (round_en) begin
            cnt_adj = cnt_q + CNT_W'(cnt_q[0]);
        end else if (step) begin
            cnt_adj = cnt_q - CNT_W'(1);
        end
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            always_comb begin
                addr_d[g*BYTE_W +: BYTE_W] = ld_addr[g] ? ld_data
                                                        : addr_stepped[g*BYTE_W +: BYTE_W];
                cnt_d[g*BYTE_W +: BYTE_W]  = ld_cnt[g] ? ld_data
                                                       : cnt_adj[g*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    assign cnt_d[CNT_W-1] = (|ld_cnt) ? 1'b0 : cnt_adj[CNT_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_d;
            cnt_q  <= cnt_d;
        end
    end

    assign addr     = addr_q;
    assign cnt      = cnt_q;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rdma_fsm.sv
module rdma_fsm
    import rdma_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned PORT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  rdma_cmd_e         cmd_code,
    input  logic              word_mode,
    input  logic              cnt_zero,
    input  logic              cnt_one,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output rdma_state_e       state,
    output logic              step,
    output logic              round_en,
    output logic              done_set,
    output logic              mem_en,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [PORT_W-1:0] port_rdata,
    output logic              port_ready
);

    rdma_state_e state_q, state_d;
    logic        lane_q;
    logic [BYTE_W-1:0] wr_lo_q, wr_hi_q, rd_lo_q, rd_hi_q;
    logic        cmd_start;

    // State register, byte lane and data latches
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lane_q  <= 1'b0;
            wr_lo_q <= '0;
            wr_hi_q <= '0;
            rd_lo_q <= '0;
            rd_hi_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_RD_TAKE, ST_WR_PUT: lane_q <= !lane_q;
                ST_RD_FETCH:           lane_q <= lane_q;
                default:               lane_q <= 1'b0;
            endcase
            if (state_q == ST_WR_ARM && port_wr) begin
                wr_lo_q <= port_wdata[BYTE_W-1:0];
                wr_hi_q <= port_wdata[PORT_W-1:BYTE_W];
            end
            if (state_q == ST_RD_TAKE) begin
                if (lane_q) begin
                    rd_hi_q <= mem_rdata;
                end else begin
                    rd_lo_q <= mem_rdata;
                end
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_RD_ARM:   if (port_rd) state_d = ST_RD_FETCH;
            ST_RD_FETCH: state_d = ST_RD_TAKE;
            ST_RD_TAKE: begin
                if (cnt_one)                     state_d = ST_IDLE;
                else if (word_mode && !lane_q)   state_d = ST_RD_FETCH;
                else                             state_d = ST_RD_ARM;
            end
            ST_WR_ARM:   if (port_wr) state_d = ST_WR_PUT;
            ST_WR_PUT: begin
                if (cnt_one)                     state_d = ST_IDLE;
                else if (word_mode && !lane_q)   state_d = ST_WR_PUT;
                else                             state_d = ST_WR_ARM;
            end
            default:     state_d = ST_IDLE;
        endcase
        if (cmd_wr) begin
            unique case (cmd_code)
                CMD_READ:  state_d = cnt_zero ? ST_IDLE : ST_RD_ARM;
                CMD_WRITE: state_d = cnt_zero ? ST_IDLE : ST_WR_ARM;
                CMD_ABORT: state_d = ST_IDLE;
                default:   ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_start  = cmd_wr && (cmd_code == CMD_READ || cmd_code == CMD_WRITE);
        step       = (state_q == ST_RD_TAKE) || (state_q == ST_WR_PUT);
        round_en   = cmd_start && word_mode;
        done_set   = (cmd_start && cnt_zero) || (step && cnt_one);
        mem_en     = (state_q == ST_RD_FETCH) || (state_q == ST_WR_PUT);
        mem_we     = (state_q == ST_WR_PUT);
        mem_wdata  = lane_q ? wr_hi_q : wr_lo_q;
        port_ready = (state_q == ST_IDLE) || (state_q == ST_RD_ARM) ||
                     (state_q == ST_WR_ARM);
        port_rdata = word_mode ? {rd_hi_q, rd_lo_q} : {{BYTE_W{1'b0}}, rd_lo_q};
    end

    assign state = state_q;

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned PTR_W  = 2 * BYTE_W,
    localparam int unsigned PORT_W = 2 * BYTE_W,
    localparam int unsigned CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_wdata,
    output logic [PORT_W-1:0] port_rdata,
    output logic              port_ready,
    output logic              dma_done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);

    rdma_state_e      fsm_state;
    rdma_cmd_e        cmd_code;
    logic [PTR_W-1:0] ptr_addr;
    logic [CNT_W-1:0] ptr_cnt;
    logic [1:0]       ld_addr, ld_cnt;
    logic             cmd_wr, word_mode, done_set, step, round_en;
    logic             cnt_zero, cnt_one;

    rdma_regfile #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ptr_addr  (ptr_addr),
        .ptr_cnt   (ptr_cnt),
        .done_set  (done_set),
        .done      (dma_done),
        .word_mode (word_mode),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .cmd_wr    (cmd_wr),
        .cmd_code  (cmd_code)
    );

    rdma_ptr #(.BYTE_W(BYTE_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ld_addr  (ld_addr),
        .ld_cnt   (ld_cnt),
        .ld_data  (reg_wdata),
        .step     (step),
        .round_en (round_en),
        .addr     (ptr_addr),
        .cnt      (ptr_cnt),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    rdma_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_code   (cmd_code),
        .word_mode  (word_mode),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .port_rd    (port_rd),
        .port_wr    (port_wr),
        .port_wdata (port_wdata),
        .mem_rdata  (mem_rdata),
        .state      (fsm_state),
        .step       (step),
        .round_en   (round_en),
        .done_set   (done_set),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .port_rdata (port_rdata),
        .port_ready (port_ready)
    );

    assign mem_addr = ptr_addr;

endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk
    import rdma_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned PTR_W = 2 * BYTE_W,
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input logic              clk,
    input logic              rst,
    input rdma_state_e       state,
    input logic [PTR_W-1:0]  addr,
    input logic [CNT_W-1:0]  cnt,
    input logic              dma_done,
    input logic              mem_we,
    input logic              port_ready,
    input logic              word_mode,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata
);

    logic ptr_load;
    assign ptr_load = reg_wr && (reg_addr == OFS_PTR_LO || reg_addr == OFS_PTR_HI);

    // R9
    idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !reg_wr) |=> ($stable(addr) && $stable(cnt)));

    // R3
    put_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_PUT && !ptr_load) |=> (addr == $past(addr) + PTR_W'(1)));

    // R9
    no_write_empty_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cnt != '0));

    // R5
    word_even_chk: assert property (@(posedge clk) disable iff (rst)
        (word_mode && (state == ST_RD_ARM || state == ST_WR_ARM)) |-> !cnt[0]);

    // R7
    done_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_done) |-> (cnt == '0));

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CMD && reg_wdata[1:0] == 2'b11)
        |=> (state == ST_IDLE && port_ready));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr == '0 && cnt == '0 && !dma_done && state == ST_IDLE));

endmodule

bind rdma_port_engine rdma_port_engine_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (fsm_state),
    .addr       (ptr_addr),
    .cnt        (ptr_cnt),
    .dma_done   (dma_done),
    .mem_we     (mem_we),
    .port_ready (port_ready),
    .word_mode  (word_mode),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata)
);

// File: tb/tb_rdma_port_engine.sv
module tb_rdma_port_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        port_rd = 1'b0;
    logic        port_wr = 1'b0;
    logic [15:0] port_wdata = '0;
    logic [15:0] port_rdata;
    logic        port_ready, dma_done, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  ram [256];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic busy_seen;

    always #5 clk = !clk;

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    rdma_port_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_rd(port_rd),
        .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .port_ready(port_ready), .dma_done(dma_done), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_ptr(output logic [15:0] v);
        logic [7:0] lo, hi;
        rreg(3'd1, lo); rreg(3'd2, hi);
        v = {hi, lo};
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rreg(3'd3, lo); rreg(3'd4, hi);
        v = {hi, lo};
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] c);
        wreg(3'd1, a[7:0]); wreg(3'd2, a[15:8]);
        wreg(3'd3, c[7:0]); wreg(3'd4, c[15:8]);
    endtask

    task automatic wait_ready();
        for (int n = 0; n < 50 && !port_ready; n++) @(negedge clk);
    endtask

    task automatic pwrite(input logic [15:0] d);
        @(negedge clk);
        port_wdata = d; port_wr = 1'b1;
        @(negedge clk);
        port_wr = 1'b0;
        busy_seen = !port_ready;
        wait_ready();
    endtask

    task automatic pread(output logic [15:0] d);
        @(negedge clk);
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
        busy_seen = !port_ready;
        wait_ready();
        d = port_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd_ptr(v); check("R11 ptr after reset", v, 16'h0);
        rd_cnt(v); check("R11 count after reset", v, 16'h0);
        check("R11 done after reset", dma_done, 1'b0);
        check("R11 ready after reset", port_ready, 1'b1);
    endtask

    task automatic t_load();
        logic [15:0] v;
        setup(16'h3C10, 16'h0103);
        rd_ptr(v); check("R1 pointer readback", v, 16'h3C10);
        rd_cnt(v); check("R2 count readback", v, 16'h0103);
    endtask

    task automatic t_byte_write();
        logic [15:0] v;
        setup(16'h0010, 16'd3);
        wreg(3'd0, 8'h02);
        pwrite(16'hEE11);
        check("R12 busy during write", busy_seen, 1'b1);
        rd_ptr(v); check("R3 ptr after one byte", v, 16'h0011);
        rd_cnt(v); check("R3 count after one byte", v, 16'd2);
        check("R7 done not early", dma_done, 1'b0);
        pwrite(16'h0022);
        pwrite(16'h0033);
        check("R3 ram 0x10", ram[8'h10], 8'h11);
        check("R3 ram 0x12", ram[8'h12], 8'h33);
        check("R7 done after last byte", dma_done, 1'b1);
        ram[8'h13] = 8'h77;
        pwrite(16'h0099);
        check("R9 ready stays high", busy_seen, 1'b0);
        rd_ptr(v); check("R9 ptr unchanged after end", v, 16'h0013);
        rd_cnt(v); check("R9 count unchanged after end", v, 16'd0);
        check("R9 ram untouched", ram[8'h13], 8'h77);
    endtask

    task automatic t_w1c();
        wreg(3'd5, 8'h00);
        check("R8 write zero keeps done", dma_done, 1'b1);
        wreg(3'd5, 8'h01);
        check("R8 write one clears done", dma_done, 1'b0);
    endtask

    task automatic t_byte_read();
        logic [15:0] d;
        setup(16'h0010, 16'd3);
        wreg(3'd0, 8'h01);
        pread(d); check("R3 read byte 0", d, 16'h0011);
        pread(d); check("R3 read byte 1", d, 16'h0022);
        pread(d); check("R3 read byte 2", d, 16'h0033);
        check("R7 done after read burst", dma_done, 1'b1);
        wreg(3'd5, 8'h01);
    endtask

    task automatic t_word();
        logic [15:0] v, d;
        wreg(3'd6, 8'h01);
        setup(16'h0020, 16'd3);
        wreg(3'd0, 8'h02);
        rd_cnt(v); check("R5 odd count rounded up", v, 16'd4);
        pwrite(16'hBBAA);
        rd_ptr(v); check("R4 ptr after one word", v, 16'h0022);
        pwrite(16'hDDCC);
        check("R4 low byte at base", ram[8'h20], 8'hAA);
        check("R4 high byte at base+1", ram[8'h21], 8'hBB);
        check("R4 second word high", ram[8'h23], 8'hDD);
        check("R7 done after word burst", dma_done, 1'b1);
        wreg(3'd5, 8'h01);
        setup(16'h0020, 16'd4);
        wreg(3'd0, 8'h01);
        pread(d); check("R4 word read 0", d, 16'hBBAA);
        pread(d); check("R4 word read 1", d, 16'hDDCC);
        wreg(3'd5, 8'h01);
        wreg(3'd6, 8'h00);
    endtask

    task automatic t_abort();
        logic [15:0] v, d;
        setup(16'h0010, 16'd2);
        wreg(3'd0, 8'h01);
        pwrite(16'h0055);
        rd_cnt(v); check("R9 wrong direction ignored", v, 16'd2);
        check("R9 ram after wrong direction", ram[8'h10], 8'h11);
        wreg(3'd0, 8'h03);
        check("R6 abort leaves done clear", dma_done, 1'b0);
        pread(d);
        rd_cnt(v); check("R6 count kept after abort", v, 16'd2);
        rd_ptr(v); check("R6 ptr kept after abort", v, 16'h0010);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        setup(16'hFFFF, 16'd2);
        wreg(3'd0, 8'h02);
        pwrite(16'h005A);
        pwrite(16'h00A5);
        check("R10 byte at 0xFFFF", ram[8'hFF], 8'h5A);
        check("R10 byte at 0x0000", ram[8'h00], 8'hA5);
        rd_ptr(v); check("R10 ptr wrapped", v, 16'h0001);
        wreg(3'd5, 8'h01);
    endtask

    task automatic t_zero();
        setup(16'h0040, 16'd0);
        wreg(3'd0, 8'h02);
        check("R7 zero count completes at once", dma_done, 1'b1);
        wreg(3'd5, 8'h01);
    endtask

    task automatic t_mid_reset();
        logic [15:0] v;
        setup(16'h1234, 16'd9);
        wreg(3'd0, 8'h02);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        rd_ptr(v); check("R11 ptr cleared mid burst", v, 16'h0);
        rd_cnt(v); check("R11 count cleared mid burst", v, 16'h0);
        check("R11 ready after mid reset", port_ready, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_byte_write();
        t_w1c();
        t_byte_read();
        t_word();
        t_abort();
        t_wrap();
        t_zero();
        t_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule